// File: doc/BRIEF.md
# Strobed-Address Two-Level Line Decoder

This block turns a 6-bit address into 64 active-low select lines, with exactly one line pulled low when the block is enabled. It is built from identical 3-bit cells. Each cell holds its address slice in a small hold register, decodes it one-hot active-low, and gates the result with a pair of enables of opposite polarity. In the wrapper, one upper cell decodes the top address slice. Each of its eight outputs drives the active-low enable of one lower cell, and the lower cells decode the bottom slice.

A shared `freeze` input controls the address path. While `freeze` is low, the path is transparent and the outputs follow the live address in the same cycle. The hold register loads the address at every rising clock edge at which `freeze` is low. While `freeze` is high, the outputs decode the held value and ignore the live address. The enables gate the outputs only. They never touch the held address.

Top module: `lat_dec_tree`

## Requirements
- R1: With the outputs enabled, exactly the output whose index equals the decoded address value (addr[5:3] selects the group of eight, addr[2:0] the line within it) is driven 0, and all others are 1.
- R2: At no time is more than one bit of `sel_n` equal to 0.
- R3: While `freeze` is 0, `sel_n` reflects the live `addr` combinationally, within the same cycle.
- R4: The hold register loads `addr` at each rising `clk` edge that samples `freeze` as 0. If `addr` changes in the same time step as `freeze` rises, the new value is not captured.
- R5: While `freeze` is 1, changes on `addr` leave `sel_n` unchanged.
- R6: All 64 bits of `sel_n` are 1 unless `en_lo_n` is 0 and `en_hi` is 1.
- R7: Disabling and re-enabling the outputs leaves the held address intact. After re-enable, the line selected before the disable is low again.
- R8: Reset clears the held address to 0. After reset, with `freeze` at 1 and the outputs enabled, only `sel_n[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the hold register |
| rst_n | input | 1 | Asynchronous active-low reset of the held address |
| freeze | input | 1 | 0: transparent address path; 1: decode the held address |
| en_lo_n | input | 1 | Output enable, active low |
| en_hi | input | 1 | Output enable, active high |
| addr | input | 6 | Address to decode |
| sel_n | output | 64 | Active-low one-hot select lines |

## Verification
Two events can land in the same cycle: the capture of the address and a change of the address itself. The bench raises `freeze` and writes a new `addr` in the same time step, then checks that the outputs still decode the earlier address, both at once and after the next clock edge. The enables and the hold path can also meet in one cycle. The bench disables the outputs while the address is frozen and moves `addr`, then re-enables them and checks that the line selected before the disable is low again. It also runs a sweep of all addresses under every enable combination in both freeze states.

// File: rtl/lat_dec_pkg.sv
package lat_dec_pkg;
  // Outputs are live only when the low-true enable is 0 and the high-true one is 1.
  function automatic logic gate_on(input logic en_lo_n, input logic en_hi);
    return (!en_lo_n) && en_hi;
  endfunction
endpackage

// File: rtl/lat_dec_hold.sv
module lat_dec_hold #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] addr_eff
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (!freeze) held_q <= addr_in;
  end

  // Transparent bypass while open, stored value while frozen.
  assign addr_eff = freeze ? held_q : addr_in;
endmodule

// File: rtl/lat_dec_cell.sv
module lat_dec_cell #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic         en_lo_n,
  input  logic         en_hi,
  input  logic [W-1:0] addr,
  output logic [N-1:0] y_n
);
  logic [W-1:0] addr_eff;
  logic         cell_on;

  function automatic logic [N-1:0] onehot_low(input logic [W-1:0] a);
    logic [N-1:0] r;
    r    = '1;
    r[a] = 1'b0;
    return r;
  endfunction

  lat_dec_hold #(.W(W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (freeze),
    .addr_in (addr),
    .addr_eff(addr_eff)
  );

  assign cell_on = lat_dec_pkg::gate_on(en_lo_n, en_hi);
  assign y_n     = cell_on ? onehot_low(addr_eff) : '1;
endmodule

// File: rtl/lat_dec_tree.sv
module lat_dec_tree #(
  parameter int CELL_W = 3,
  localparam int ADDR_W = 2 * CELL_W,
  localparam int CELL_N = 1 << CELL_W,
  localparam int OUT_W  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              en_lo_n,
  input  logic              en_hi,
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  sel_n
);
  // Named internal events for the checker.
  logic              out_enabled;
  logic [CELL_N-1:0] grp_n;

  assign out_enabled = lat_dec_pkg::gate_on(en_lo_n, en_hi);

  lat_dec_cell #(.W(CELL_W)) u_upper (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (freeze),
    .en_lo_n(en_lo_n),
    .en_hi  (en_hi),
    .addr   (addr[ADDR_W-1:CELL_W]),
    .y_n    (grp_n)
  );

  for (genvar g = 0; g < CELL_N; g++) begin : g_lower
    lat_dec_cell #(.W(CELL_W)) u_lower (
      .clk    (clk),
      .rst_n  (rst_n),
      .freeze (freeze),
      .en_lo_n(grp_n[g]),
      .en_hi  (1'b1),
      .addr   (addr[CELL_W-1:0]),
      .y_n    (sel_n[g*CELL_N +: CELL_N])
    );
  end
endmodule

// File: rtl/lat_dec_checker.sv
module lat_dec_checker #(
  parameter int ADDR_W = 6,
  parameter int OUT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze,
  input logic              en_lo_n,
  input logic              en_hi,
  input logic              out_enabled,
  input logic [ADDR_W-1:0] addr,
  input logic [OUT_W-1:0]  sel_n
);
  a_r2_at_most_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);

  a_r6_disabled_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lo_n || !en_hi) |-> (&sel_n));

  a_r3_transparent_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && out_enabled) |-> !sel_n[addr]);

  a_r4_capture_prior: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(freeze) && out_enabled) |-> !sel_n[$past(addr)]);

  a_r5_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && $past(freeze) && out_enabled && $stable(en_lo_n) && $stable(en_hi))
      |-> $stable(sel_n));
endmodule

bind lat_dec_tree lat_dec_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .freeze     (freeze),
  .en_lo_n    (en_lo_n),
  .en_hi      (en_hi),
  .out_enabled(out_enabled),
  .addr       (addr),
  .sel_n      (sel_n)
);

// File: tb/tb_lat_dec_tree.sv
module tb_lat_dec_tree;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        freeze = 1'b1;
  logic        en_lo_n = 1'b0;
  logic        en_hi = 1'b1;
  logic [5:0]  addr = 6'd5;
  logic [63:0] sel_n;

  int checks = 0;
  int failures = 0;
  logic [5:0] m_hold;

  lat_dec_tree dut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .en_lo_n(en_lo_n),
    .en_hi(en_hi), .addr(addr), .sel_n(sel_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Independent model of the held address, taken from R4 and R8.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       m_hold <= 6'd0;
    else if (!freeze) m_hold <= addr;
  end

  function automatic logic [63:0] expect_sel(input logic f, input logic el,
                                             input logic eh, input logic [5:0] a,
                                             input logic [5:0] h);
    logic [63:0] r;
    r = {64{1'b1}};
    if (!el && eh) r = ~(64'd1 << (f ? h : a));
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic el, input logic eh, input logic [5:0] a);
    @(negedge clk);
    freeze = f; en_lo_n = el; en_hi = eh; addr = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] e;
    #1 rst_n = 1'b0;
    #1;
    // R8: reset clears held address; frozen and enabled selects line 0.
    chk(sel_n === ~64'd1, "R8 reset", sel_n, ~64'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(sel_n === ~64'd1, "R8 after reset", sel_n, ~64'd1);

    // R4: freeze rises together with an address change.
    drive(1'b0, 1'b0, 1'b1, 6'd45);
    chk(sel_n === ~(64'd1 << 45), "R3 open", sel_n, ~(64'd1 << 45));
    drive(1'b1, 1'b0, 1'b1, 6'd18);
    chk(sel_n === ~(64'd1 << 45), "R4 same step", sel_n, ~(64'd1 << 45));
    @(negedge clk); #1;
    chk(sel_n === ~(64'd1 << 45), "R4 after edge", sel_n, ~(64'd1 << 45));

    // R7: disable, move address, re-enable.
    drive(1'b1, 1'b0, 1'b0, 6'd7);
    chk(&sel_n, "R6 disabled", sel_n, {64{1'b1}});
    drive(1'b1, 1'b1, 1'b1, 6'd60);
    chk(&sel_n, "R6 disabled lo", sel_n, {64{1'b1}});
    drive(1'b1, 1'b0, 1'b1, 6'd60);
    chk(sel_n === ~(64'd1 << 45), "R7 held kept", sel_n, ~(64'd1 << 45));

    // Sweep: both freeze states, all enable pairs, all addresses.
    for (int f = 0; f < 2; f++) begin
      for (int en = 0; en < 4; en++) begin
        for (int a = 0; a < 64; a++) begin
          drive(f[0], en[1], en[0], a[5:0]);
          e = expect_sel(f[0], en[1], en[0], a[5:0], m_hold);
          chk(sel_n === e,
              (en != 1) ? "R6 gate" : (f != 0) ? "R5 frozen" : "R1 decode",
              sel_n, e);
          chk($countones(~sel_n) <= 1, "R2 one low", sel_n, e);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule